// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the configuration port of a larger device. An external master selects it with an active-low chip select, clocks it with a serial clock, and moves byte-wide register values in and out. The block never drives the serial clock. It samples the serial clock, the chip select and the data input in its own system clock domain through a short synchronizer chain. A transaction opens with a 16-bit command word that carries a direction flag, a length code and a start address. The data bytes that follow are written to or read from a small register bank, and the address steps after every byte.

Read data leaves on the shared data line, using a separate output-enable, in three-wire mode. In four-wire mode it leaves on a dedicated output. Register 0 holds the mode controls: the wire mode and the bit order. In least-significant-first order the address counts down instead of up. The master may raise chip select to pause a short transfer at a byte boundary. For an open-ended stream, a pause is tolerated only before the data starts.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset, register 0 reads 0x00 (three-wire, most-significant-first), and `sdio_oe` and `sdo_o` are low.
- R2: The command word is 16 bits: bit 15 is the direction (1 = read), bits 14:13 are the length code (00 = 1 byte, 01 = 2, 10 = 3, 11 = unlimited until chip select ends it), and bits 12:0 are the start address. Once a counted transfer has moved its bytes, further bytes are ignored.
- R3: In a write, every complete byte is stored at the current address, and the address then increments in most-significant-first order.
- R4: In a read, the byte at the current address is presented one bit per serial clock period. Each bit is valid before the rising edge that ends its period, and the address advances after every byte.
- R5: Register 0 bit 7 selects four-wire mode and bit 6 selects least-significant-first order. Its other bits read as 0.
- R6: In least-significant-first order, the command word and the data bytes travel bit 0 first, and the address decrements after every byte.
- R7: In three-wire mode, `sdio_oe` is high during the data part of a read while chip select is low, and low at all other times. `sdo_o` stays low.
- R8: In four-wire mode, read data appears on `sdo_o`, `sdio_oe` stays low, and `sdo_o` is low while chip select is high.
- R9: For length codes 00, 01 and 10, raising chip select at any byte boundary pauses the transfer. After chip select falls again, the transfer continues with the next bit.
- R10: For the unlimited length code, a pause between the two command bytes or before the first data byte is tolerated. A chip select rise after a data byte ends the transfer, and the next bits form a new command word.
- R11: Only address bits 7:0 select a register. Registers 1 to NUM_REGS-1 are storage. Writes to addresses from NUM_REGS upward are ignored, and reads from them return 0x00.
- R12: A chip select rise in the middle of a byte abandons the transfer, and the next transaction starts with a fresh command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to sample all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master, idle low |
| csb_i | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data input (input side of the shared data line) |
| sdio_o | output | 1 | Read data for the shared data line |
| sdio_oe | output | 1 | Output enable for the shared data line |
| sdo_o | output | 1 | Dedicated read data output in four-wire mode |

## Verification
The hardest cases to reach are the chip select pause rules, because they depend on where a chip select rise falls relative to the byte count and the length code. The directed tasks split transfers by hand. They pause a three-byte write after its command word and after its first byte, pause a stream between its two command bytes and before its data, and end a stream after one data byte and then send a read command straight away. The read shows that the stream was closed, and a follow-up read shows that the bytes after the pause wrote nothing. A five-bit abort is followed by a normal transaction to show that the framing restarts.

// File: rtl/cfg_spi_pkg.sv
// Shared constants and types for the serial configuration slave.
// Assumes a 16-bit command word with the address in its low bits.
package cfg_spi_pkg;
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    localparam int          CMD_BITS      = 16;
    localparam int          START_BITS    = 13;
    localparam int          CTRL_FOURW    = 7;
    localparam int          CTRL_LSBF     = 6;
    localparam logic [1:0]  LEN_UNLIMITED = 2'b11;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings the serial clock, chip select and data pins into the system clock
// domain and flags serial clock rises and chip select rises.
// Assumes the serial clock is slower than a quarter of the system clock.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic csb_i,
    input  logic sdi_i,
    output logic sclk_rise,
    output logic csb_rise,
    output logic csb_lvl,
    output logic sdi_lvl
);
    logic [STAGES-1:0] sclk_sr, csb_sr, sdi_sr;
    logic              sclk_d, csb_d;

    // Purpose: shift the pins through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sr <= '0;
            csb_sr  <= '1;
            sdi_sr  <= '0;
            sclk_d  <= 1'b0;
            csb_d   <= 1'b1;
        end else begin
            sclk_sr <= {sclk_sr[STAGES-2:0], sclk_i};
            csb_sr  <= {csb_sr[STAGES-2:0], csb_i};
            sdi_sr  <= {sdi_sr[STAGES-2:0], sdi_i};
            sclk_d  <= sclk_sr[STAGES-1];
            csb_d   <= csb_sr[STAGES-1];
        end
    end

    assign sclk_rise = sclk_sr[STAGES-1] & ~sclk_d;
    assign csb_rise  = csb_sr[STAGES-1] & ~csb_d;
    assign csb_lvl   = csb_sr[STAGES-1];
    assign sdi_lvl   = sdi_sr[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
// Frames a transaction: collects the command word, counts data bits and
// bytes, steps the address, issues write strobes and applies the chip
// select pause rules. Assumes a chip select rise and a serial clock rise
// never land in the same system clock cycle.
module spi_frame_ctrl
    import cfg_spi_pkg::*;
#(
    parameter int CW = CMD_BITS,
    parameter int AW = START_BITS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_rise,
    input  logic       csb_rise,
    input  logic       csb_lvl,
    input  logic       sdi,
    input  logic       lsb_first,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic [7:0] cur_addr,
    output logic [2:0] bit_idx,
    output logic       rd_active
);
    localparam int CNT_W = $clog2(CW);

    phase_t            phase;
    logic [CNT_W-1:0]  cmd_cnt;
    logic [2:0]        bit_cnt;
    logic [CW-1:0]     cmd_sr, cmd_nxt;
    logic [7:0]        dat_sr, dat_nxt;
    logic              rd_q;
    logic [1:0]        len_q, nbytes_q;
    logic [AW-1:0]     addr_q, addr_step;
    logic              mid_byte, may_pause, byte_last;

    // Purpose: next shift values in the selected bit order and address step.
    always_comb begin
        cmd_nxt   = lsb_first ? {sdi, cmd_sr[CW-1:1]} : {cmd_sr[CW-2:0], sdi};
        dat_nxt   = lsb_first ? {sdi, dat_sr[7:1]}    : {dat_sr[6:0], sdi};
        addr_step = lsb_first ? addr_q - 1'b1 : addr_q + 1'b1;
        byte_last = (len_q != LEN_UNLIMITED) && (nbytes_q == len_q);
        mid_byte  = ((phase == PH_HDR) && (cmd_cnt[2:0] != 3'd0)) ||
                    ((phase == PH_DATA) && (bit_cnt != 3'd0));
        case (phase)
            PH_HDR:  may_pause = !mid_byte;
            PH_DATA: may_pause = !mid_byte &&
                                 ((len_q != LEN_UNLIMITED) || (nbytes_q == 2'd0));
            default: may_pause = 1'b0;
        endcase
    end

    // Purpose: advance the transaction on serial clock and chip select events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_HDR;
            cmd_cnt  <= '0;
            bit_cnt  <= '0;
            cmd_sr   <= '0;
            dat_sr   <= '0;
            rd_q     <= 1'b0;
            len_q    <= '0;
            nbytes_q <= '0;
            addr_q   <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (csb_rise) begin
                if (!may_pause) begin
                    phase   <= PH_HDR;
                    cmd_cnt <= '0;
                    bit_cnt <= '0;
                end
            end else if (sclk_rise && !csb_lvl) begin
                case (phase)
                    PH_HDR: begin
                        cmd_sr  <= cmd_nxt;
                        cmd_cnt <= cmd_cnt + 1'b1;
                        if (cmd_cnt == CNT_W'(CW - 1)) begin
                            phase    <= PH_DATA;
                            rd_q     <= cmd_nxt[CW-1];
                            len_q    <= cmd_nxt[CW-2 -: 2];
                            addr_q   <= cmd_nxt[AW-1:0];
                            bit_cnt  <= '0;
                            nbytes_q <= '0;
                        end
                    end
                    PH_DATA: begin
                        dat_sr  <= dat_nxt;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == 3'd7) begin
                            wr_en   <= !rd_q;
                            wr_addr <= addr_q[7:0];
                            wr_data <= dat_nxt;
                            addr_q  <= addr_step;
                            if (byte_last)
                                phase <= PH_DONE;
                            else if (nbytes_q != 2'd3)
                                nbytes_q <= nbytes_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign cur_addr  = addr_q[7:0];
    assign bit_idx   = bit_cnt;
    assign rd_active = rd_q && ((phase == PH_DATA) || (phase == PH_DONE));
endmodule

// File: rtl/spi_reg_file.sv
// Register bank: entry 0 holds the two mode bits, entries 1 to NUM_REGS-1
// are plain storage, and everything above reads as zero and ignores writes.
// Assumes NUM_REGS is between 2 and 256.
module spi_reg_file
    import cfg_spi_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_addr,
    output logic [7:0]            rd_data,
    output logic                  four_wire,
    output logic                  lsb_first,
    output logic [8*NUM_REGS-1:0] regs_flat
);
    logic [1:0] ctrl_q;

    // Purpose: hold the mode bits of entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && (wr_addr == 8'd0))
            ctrl_q <= {wr_data[CTRL_FOURW], wr_data[CTRL_LSBF]};
    end

    assign regs_flat[7:0] = {ctrl_q, 6'b0};
    assign four_wire      = ctrl_q[1];
    assign lsb_first      = ctrl_q[0];

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_store
        logic [7:0] val_q;
        // Purpose: hold one storage entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (wr_en && (wr_addr == 8'(g)))
                val_q <= wr_data;
        end
        assign regs_flat[g*8 +: 8] = val_q;
    end

    // Purpose: read multiplexer, zero for unmapped addresses.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == 8'(i))
                rd_data = regs_flat[i*8 +: 8];
    end
endmodule

// File: rtl/cfg_spi_slave.sv
// Top of the serial configuration slave: synchronizer, framing, register
// bank and pin steering. Assumes the serial clock idles low and that read
// data is sampled by the master on rising serial clock edges.
module cfg_spi_slave #(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic csb_i,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe,
    output logic sdo_o
);
    logic                  sclk_rise, csb_rise, csb_lvl, sdi_lvl;
    logic                  wr_en, rd_active, four_wire, lsb_first, out_bit;
    logic [7:0]            wr_addr, wr_data, cur_addr, rd_data;
    logic [2:0]            bit_idx;
    logic [8*NUM_REGS-1:0] regs_flat;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csb_i(csb_i), .sdi_i(sdio_i),
        .sclk_rise(sclk_rise), .csb_rise(csb_rise), .csb_lvl(csb_lvl), .sdi_lvl(sdi_lvl)
    );

    spi_frame_ctrl i_frame (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .csb_rise(csb_rise),
        .csb_lvl(csb_lvl), .sdi(sdi_lvl), .lsb_first(lsb_first),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cur_addr(cur_addr), .bit_idx(bit_idx), .rd_active(rd_active)
    );

    spi_reg_file #(.NUM_REGS(NUM_REGS)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(cur_addr), .rd_data(rd_data),
        .four_wire(four_wire), .lsb_first(lsb_first), .regs_flat(regs_flat)
    );

    // Purpose: pick the current read bit in the selected order.
    assign out_bit = lsb_first ? rd_data[bit_idx] : rd_data[3'd7 - bit_idx];

    assign sdio_oe = rd_active & ~csb_lvl & ~four_wire;
    assign sdio_o  = sdio_oe & out_bit;
    assign sdo_o   = four_wire & ~csb_lvl & rd_active & out_bit;
endmodule

// File: rtl/cfg_spi_slave_chk.sv
// Property checker for cfg_spi_slave, attached with bind below.
// Assumes a two-stage chip select synchronizer (default SYNC_STAGES).
module cfg_spi_slave_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  csb_i,
    input logic                  sdio_oe,
    input logic                  sdo_o,
    input logic                  four_wire,
    input logic                  lsb_first,
    input logic                  wr_en,
    input logic [7:0]            wr_addr,
    input logic [7:0]            wr_data,
    input logic [8*NUM_REGS-1:0] regs_flat
);
    assert_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!four_wire && !lsb_first && !sdio_oe && !sdo_o));

    assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != 8'd0) && (int'(wr_addr) < NUM_REGS)) |=>
        (regs_flat[int'($past(wr_addr))*8 +: 8] == $past(wr_data)));

    assert_mode_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 8'd0)) |=>
        ((four_wire == $past(wr_data[7])) && (lsb_first == $past(wr_data[6]))));

    assert_oe_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> (!four_wire && !$past(csb_i, 2)));

    assert_sdo_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_o |-> (four_wire && !$past(csb_i, 2) && !sdio_oe));

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) >= NUM_REGS)) |=> $stable(regs_flat));
endmodule

bind cfg_spi_slave cfg_spi_slave_chk #(.NUM_REGS(NUM_REGS)) i_chk (
    .clk(clk), .rst_n(rst_n), .csb_i(csb_i), .sdio_oe(sdio_oe), .sdo_o(sdo_o),
    .four_wire(four_wire), .lsb_first(lsb_first), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .regs_flat(regs_flat)
);

// File: tb/test_cfg_spi_slave.sv
// Directed bench for cfg_spi_slave: one task per scenario.
module test_cfg_spi_slave;
    localparam int HALF = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, csb = 1'b1, sdi = 1'b0;
    logic sdio_o, sdio_oe, sdo_o;
    int   checks = 0, errors = 0;
    bit   tb_lsb = 0, tb_fourw = 0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always #4 clk = ~clk;

    cfg_spi_slave i_cfg_spi_slave (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csb_i(csb), .sdio_i(sdi),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic d, output logic q);
        sdi = d;
        wait_clk(HALF);
        q = tb_fourw ? sdo_o : sdio_o;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] q);
        for (int i = 0; i < 8; i++) begin
            int idx;
            idx = tb_lsb ? i : 7 - i;
            send_bit(b[idx], q[idx]);
        end
    endtask

    task automatic send_cmd(input bit rd, input logic [1:0] len, input logic [12:0] addr);
        logic [15:0] w;
        logic [7:0]  dummy;
        w = {rd, len, addr};
        if (tb_lsb) begin
            send_byte(w[7:0], dummy);
            send_byte(w[15:8], dummy);
        end else begin
            send_byte(w[15:8], dummy);
            send_byte(w[7:0], dummy);
        end
    endtask

    task automatic cs_on();
        csb = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_off();
        wait_clk(HALF);
        csb = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic xfer(input bit rd, input logic [1:0] len, input logic [12:0] addr, input int n);
        cs_on();
        send_cmd(rd, len, addr);
        for (int i = 0; i < n; i++) send_byte(wbuf[i], rbuf[i]);
        cs_off();
    endtask

    task automatic wr1(input logic [12:0] addr, input logic [7:0] d);
        wbuf[0] = d;
        xfer(1'b0, 2'b00, addr, 1);
    endtask

    task automatic rd1(input logic [12:0] addr, input string req, input logic [7:0] exp);
        wbuf[0] = 8'h00;
        xfer(1'b1, 2'b00, addr, 1);
        chk(req, rbuf[0], exp);
    endtask

    task automatic t_reset();
        chk("R1 sdio_oe after reset", {7'd0, sdio_oe}, 8'h00);
        chk("R1 sdo_o after reset", {7'd0, sdo_o}, 8'h00);
        rd1(13'h000, "R1 control register after reset", 8'h00);
    endtask

    task automatic t_burst_msb();
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        xfer(1'b0, 2'b10, 13'h001, 3);
        wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
        xfer(1'b1, 2'b10, 13'h001, 3);
        chk("R4 burst read byte 0", rbuf[0], 8'hA1);
        chk("R4 burst read byte 1", rbuf[1], 8'hB2);
        chk("R4 burst read byte 2", rbuf[2], 8'hC3);
        rd1(13'h002, "R3 incremented write lands at 2", 8'hB2);
    endtask

    task automatic t_count_limit();
        wbuf[0] = 8'h55; wbuf[1] = 8'h77;
        xfer(1'b0, 2'b00, 13'h004, 2);
        rd1(13'h004, "R2 single byte stored", 8'h55);
        rd1(13'h005, "R2 extra byte ignored", 8'h00);
    endtask

    task automatic t_three_wire_oe();
        logic [7:0] q;
        cs_on();
        chk("R7 oe low before command", {7'd0, sdio_oe}, 8'h00);
        send_cmd(1'b1, 2'b00, 13'h001);
        chk("R7 oe high in read data", {7'd0, sdio_oe}, 8'h01);
        chk("R7 sdo_o low in three-wire", {7'd0, sdo_o}, 8'h00);
        send_byte(8'h00, q);
        chk("R4 three-wire read data", q, 8'hA1);
        cs_off();
        chk("R7 oe low after chip select rise", {7'd0, sdio_oe}, 8'h00);
    endtask

    task automatic t_unmapped();
        wr1(13'h020, 8'h99);
        rd1(13'h020, "R11 unmapped read is zero", 8'h00);
        wr1(13'h102, 8'h3C);
        rd1(13'h002, "R11 upper address bits ignored", 8'h3C);
    endtask

    task automatic t_short_pause();
        logic [7:0] q;
        cs_on();
        send_cmd(1'b0, 2'b10, 13'h005);
        cs_off(); cs_on();
        send_byte(8'h11, q);
        cs_off(); cs_on();
        send_byte(8'h22, q);
        send_byte(8'h33, q);
        cs_off();
        wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
        xfer(1'b1, 2'b10, 13'h005, 3);
        chk("R9 paused write byte 0", rbuf[0], 8'h11);
        chk("R9 paused write byte 1", rbuf[1], 8'h22);
        chk("R9 paused write byte 2", rbuf[2], 8'h33);
    endtask

    task automatic t_abort();
        logic q;
        cs_on();
        for (int i = 0; i < 5; i++) send_bit(1'b1, q);
        cs_off();
        wr1(13'h006, 8'h5A);
        rd1(13'h006, "R12 fresh command after abort", 8'h5A);
        rd1(13'h007, "R12 aborted bits wrote nothing", 8'h33);
    endtask

    task automatic t_stream();
        logic [7:0] q;
        cs_on();
        send_byte(8'h60, q);          // write, unlimited, address high bits 0
        cs_off(); cs_on();
        send_byte(8'h01, q);          // start address 1
        cs_off(); cs_on();
        for (int i = 0; i < 5; i++) send_byte(8'(i + 1), q);
        cs_off();
        for (int i = 0; i < 5; i++) wbuf[i] = 8'h00;
        xfer(1'b1, 2'b11, 13'h001, 5);
        for (int i = 0; i < 5; i++)
            chk("R10 stream after tolerated pauses", rbuf[i], 8'(i + 1));
        cs_on();
        send_cmd(1'b0, 2'b11, 13'h001);
        send_byte(8'hEE, q);
        cs_off(); cs_on();
        send_cmd(1'b1, 2'b00, 13'h003);
        send_byte(8'h00, q);
        cs_off();
        chk("R10 new command after ended stream", q, 8'h03);
        rd1(13'h002, "R10 no write after stream ended", 8'h02);
        rd1(13'h001, "R10 byte before end stored", 8'hEE);
    endtask

    task automatic t_lsb_first();
        wr1(13'h000, 8'h40);
        tb_lsb = 1;
        rd1(13'h000, "R5 control reads lsb-first bit", 8'h40);
        wbuf[0] = 8'h81; wbuf[1] = 8'h3E;
        xfer(1'b0, 2'b01, 13'h005, 2);
        rd1(13'h005, "R6 lsb-first first byte", 8'h81);
        rd1(13'h004, "R6 address decremented", 8'h3E);
        wbuf[0] = 0; wbuf[1] = 0;
        xfer(1'b1, 2'b01, 13'h005, 2);
        chk("R6 lsb-first read byte 0", rbuf[0], 8'h81);
        chk("R6 lsb-first read byte 1", rbuf[1], 8'h3E);
    endtask

    task automatic t_four_wire();
        logic [7:0] q0, q1;
        wr1(13'h000, 8'hFF);
        tb_fourw = 1;
        rd1(13'h000, "R5 unused control bits read zero", 8'hC0);
        cs_on();
        send_cmd(1'b1, 2'b01, 13'h005);
        chk("R8 sdio_oe low in four-wire", {7'd0, sdio_oe}, 8'h00);
        send_byte(8'h00, q0);
        send_byte(8'h00, q1);
        cs_off();
        chk("R8 four-wire byte 0", q0, 8'h81);
        chk("R8 four-wire byte 1", q1, 8'h3E);
        chk("R8 sdo_o low with chip select high", {7'd0, sdo_o}, 8'h00);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_burst_msb();
        t_count_limit();
        t_three_wire_oe();
        t_unmapped();
        t_short_pause();
        t_abort();
        t_stream();
        t_lsb_first();
        t_four_wire();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule